// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the register front end of a security module's command-response buffer interface. Software reaches it over a simple byte-addressable bus that accepts accesses of 1 to 4 bytes, little-endian. It tracks whether a locality is held, keeps the idle and fatal-error status, launches commands to a backend engine, and forwards cancel requests to that engine. A set of read-only identification and buffer-description words tells software how the interface is built and where the data buffer sits. The data RAM and the backend engine are outside the block.

Control writes act only when the written value matches a defined code exactly, and every other value is dropped. Two small state machines carry the behaviour. The command machine has the states READY (no command in flight) and BUSY (command in flight). Its transition LAUNCH (READY to BUSY) is taken on an accepted start write. Its transition FINISH (BUSY to READY) is taken on a backend completion pulse. The locality machine has the states FREE and HELD. Its transition ACQUIRE (FREE to HELD) is taken on a request-access write, and its transition RELEASE (HELD to FREE) on a relinquish write. The active locality is fixed at 0.

Top module: `cmdbuf_ctrl_regs`

Register map (offset = address bits [11:0]; address bits [15:12] carry the locality of a write). Unused bits read as zero.

| Offset | Name | Fields |
|---|---|---|
| 0x000 | LOCSTATE | bit0 not-established (inverse of `est_flag`), bit1 assigned, bit7 register-valid, bits[15:8] active locality (0xFF when none assigned) |
| 0x008 | LOCCTRL | write-only: 0x1 request access, 0x2 relinquish, 0x4 seize (no effect), 0x8 reset-establishment (no effect) |
| 0x00C | LOCSTS | bit0 granted, bit1 been-seized |
| 0x030 | IFID | bits[3:0] type=1, [7:4] version=1, bit8 locality capability=0, bit9 idle bypass=0, [11:10] transfer size=3, bit12 FIFO=0, bit14 CRB=1, [18:17] selector=1, [27:24] revision=0; resets to 0x00024C11 |
| 0x034 | IFID2 | bits[15:0] vendor code (default 0x1014) |
| 0x040 | CTLREQ | write-only: 0x1 command ready, 0x2 go idle |
| 0x044 | CTLSTS | bit0 fatal error, bit1 idle |
| 0x048 | CANCEL | write 0x1 to cancel; reads 0 |
| 0x04C | START | bit0 command in flight |
| 0x058 / 0x064 | CMDSZ / RSPSZ | buffer size = window size - data offset (0xF80 by default) |
| 0x05C / 0x068 | CMDADR / RSPADR | window base + data offset (0xFED40080 by default) |

## Requirements
- R1: After reset LOCSTATE reads 0x0000FF80 with bit0 set to the inverse of `est_flag`, CTLSTS reads 0x2, START reads 0, IFID reads 0x00024C11, IFID2 reads 0x00001014, both size words read 0xF80, and both address words read 0xFED40080.
- R2: A write of exactly 0x1 to CTLREQ clears the idle bit (CTLSTS bit1). A write of exactly 0x2 sets it. Any other value leaves it unchanged.
- R3: A LOCCTRL write of 0x1 sets granted (LOCSTS bit0), clears been-seized (LOCSTS bit1) and sets assigned (LOCSTATE bit1). A write of 0x2 clears granted and assigned. Writes of 0x4 and 0x8 change nothing.
- R4: LOCSTATE bits[15:8] read 0xFF while no locality is assigned and 0x00 while one is.
- R5: A START write of exactly 0x1 is accepted when START bit0 is clear, a locality is assigned and write address bits [15:12] equal 0. It then sets START bit0 and drives `be_req` high for exactly one cycle, the cycle after the write.
- R6: A START write is rejected, with no `be_req` pulse and START unchanged, when the value is not exactly 0x1, when no locality is assigned, when address bits [15:12] are nonzero, or when START bit0 is already set.
- R7: A CANCEL write of exactly 0x1 pulses `be_cancel` for one cycle, the cycle after the write, only while START bit0 is set. Otherwise it has no effect.
- R8: A `be_done` pulse while START bit0 is set clears it. If `be_err` is high with the pulse, the fatal bit (CTLSTS bit0) is set and stays set until reset.
- R9: A `be_done` pulse while START bit0 is clear is ignored, even with `be_err` high.
- R10: A read returns the word at the word-aligned address shifted right by 8 times address bits [1:0], and LOCSTATE bit0 follows the inverse of `est_flag` at all times.
- R11: A write is compared only on its written byte lanes (`bus_len` = bytes - 1, data right-aligned). A 1-byte write of 0x00000101 to CTLREQ acts as 0x01, and a 4-byte write of the same data is ignored.
- R12: A CANCEL write and a `be_done` pulse in the same cycle while a command is in flight both take effect: `be_cancel` pulses and START bit0 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address; bits [15:12] are the locality of a write |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_len | input | 2 | Access length minus one, in bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| est_flag | input | 1 | Established flag from outside; its inverse shows in LOCSTATE bit0 |
| be_req | output | 1 | One-cycle command launch pulse to the backend |
| be_cancel | output | 1 | One-cycle cancel pulse to the backend |
| be_done | input | 1 | Completion pulse from the backend |
| be_err | input | 1 | Error flag, qualified by `be_done` |

## Verification
The collision that matters is a cancel write landing in the same cycle as the backend's completion pulse. In that cycle the cancel decision sees the command as in flight, while FINISH retires it. The bench produces this by raising `be_done` during the CANCEL write's strobe cycle. It then requires a `be_cancel` pulse in the next cycle and START reading 0 afterwards. A second collision, a START write arriving while BUSY, must produce no `be_req`.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic {ST_READY, ST_BUSY} cmd_state_t;
    typedef enum logic {LOC_FREE, LOC_HELD} loc_state_t;

    localparam logic [11:0] OFS_LOCSTATE = 12'h000;
    localparam logic [11:0] OFS_LOCCTRL  = 12'h008;
    localparam logic [11:0] OFS_LOCSTS   = 12'h00C;
    localparam logic [11:0] OFS_IFID     = 12'h030;
    localparam logic [11:0] OFS_IFID2    = 12'h034;
    localparam logic [11:0] OFS_CTLREQ   = 12'h040;
    localparam logic [11:0] OFS_CTLSTS   = 12'h044;
    localparam logic [11:0] OFS_CANCEL   = 12'h048;
    localparam logic [11:0] OFS_START    = 12'h04C;
    localparam logic [11:0] OFS_CMDSZ    = 12'h058;
    localparam logic [11:0] OFS_CMDADR   = 12'h05C;
    localparam logic [11:0] OFS_RSPSZ    = 12'h064;
    localparam logic [11:0] OFS_RSPADR   = 12'h068;

    localparam logic [31:0] CODE_CMD_READY = 32'h1;
    localparam logic [31:0] CODE_GO_IDLE   = 32'h2;
    localparam logic [31:0] CODE_INVOKE    = 32'h1;
    localparam logic [31:0] CODE_LOC_REQ   = 32'h1;
    localparam logic [31:0] CODE_LOC_REL   = 32'h2;

    localparam logic [3:0] ACTIVE_LOC = 4'd0;

    function automatic logic [31:0] ifid_word();
        logic [31:0] w;
        w        = '0;
        w[3:0]   = 4'd1;   // interface type: active
        w[7:4]   = 4'd1;   // interface version
        w[8]     = 1'b0;   // locality 0 only
        w[9]     = 1'b0;   // no idle bypass
        w[11:10] = 2'b11;  // 64-byte transfers
        w[12]    = 1'b0;   // no FIFO
        w[14]    = 1'b1;   // CRB supported
        w[18:17] = 2'd1;   // selector
        w[27:24] = 4'd0;   // revision
        return w;
    endfunction

endpackage

// File: rtl/cmdbuf_bus_decode.sv
module cmdbuf_bus_decode
    import cmdbuf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        len,
    input  logic [31:0]       wdata,
    output logic              hit_cmd_ready,
    output logic              hit_go_idle,
    output logic              hit_start,
    output logic              hit_cancel,
    output logic              hit_loc_req,
    output logic              hit_loc_rel,
    output logic [3:0]        wr_loc
);
    logic [31:0] lane_mask;
    logic [31:0] val;
    logic [11:0] ofs;

    always_comb begin
        unique case (len)
            2'd0: lane_mask = 32'h0000_00FF;
            2'd1: lane_mask = 32'h0000_FFFF;
            2'd2: lane_mask = 32'h00FF_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    end

    assign val    = wdata & lane_mask;
    assign ofs    = addr[11:0];
    assign wr_loc = addr[ADDR_W-1:ADDR_W-4];

    assign hit_cmd_ready = wr_en && ofs == OFS_CTLREQ  && val == CODE_CMD_READY;
    assign hit_go_idle   = wr_en && ofs == OFS_CTLREQ  && val == CODE_GO_IDLE;
    assign hit_start     = wr_en && ofs == OFS_START   && val == CODE_INVOKE;
    assign hit_cancel    = wr_en && ofs == OFS_CANCEL  && val == CODE_INVOKE;
    assign hit_loc_req   = wr_en && ofs == OFS_LOCCTRL && val == CODE_LOC_REQ;
    assign hit_loc_rel   = wr_en && ofs == OFS_LOCCTRL && val == CODE_LOC_REL;

    always_comb begin
        assert ($onehot0({hit_cmd_ready, hit_go_idle, hit_start,
                          hit_cancel, hit_loc_req, hit_loc_rel}))
            else $error("assert_single_hit_R11");
    end
endmodule

// File: rtl/cmdbuf_loc_fsm.sv
module cmdbuf_loc_fsm
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_loc_req,
    input  logic hit_loc_rel,
    output logic held,
    output logic granted,
    output logic seized
);
    loc_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LOC_FREE: if (hit_loc_req) state_nx = LOC_HELD;  // ACQUIRE
            LOC_HELD: if (hit_loc_rel) state_nx = LOC_FREE;  // RELEASE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LOC_FREE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted <= 1'b0;
            seized  <= 1'b0;
        end else if (hit_loc_req) begin
            granted <= 1'b1;
            seized  <= 1'b0;
        end else if (hit_loc_rel) begin
            granted <= 1'b0;
        end
    end

    assign held = (state == LOC_HELD);

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_loc_rel |=> (!held && !granted));
    assert_acquire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_loc_req |=> (held && granted && !seized));
endmodule

// File: rtl/cmdbuf_cmd_fsm.sv
module cmdbuf_cmd_fsm
    import cmdbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_start,
    input  logic       hit_cancel,
    input  logic       hit_cmd_ready,
    input  logic       hit_go_idle,
    input  logic       loc_held,
    input  logic [3:0] wr_loc,
    input  logic       done_i,
    input  logic       err_i,
    output logic       busy,
    output logic       idle_sts,
    output logic       fatal_sts,
    output logic       req_o,
    output logic       cancel_o
);
    cmd_state_t state, state_nx;
    logic       start_ok;

    assign start_ok = hit_start && loc_held && (wr_loc == ACTIVE_LOC);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: if (start_ok) state_nx = ST_BUSY;   // LAUNCH
            ST_BUSY:  if (done_i)   state_nx = ST_READY;  // FINISH
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o     <= 1'b0;
            cancel_o  <= 1'b0;
            fatal_sts <= 1'b0;
            idle_sts  <= 1'b1;
        end else begin
            req_o    <= (state == ST_READY) && start_ok;
            cancel_o <= (state == ST_BUSY) && hit_cancel;
            if ((state == ST_BUSY) && done_i && err_i) fatal_sts <= 1'b1;
            if (hit_cmd_ready)    idle_sts <= 1'b0;
            else if (hit_go_idle) idle_sts <= 1'b1;
        end
    end

    assign busy = (state == ST_BUSY);

    assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> busy);
    assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    assert_cancel_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> $past(busy));
    assert_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done_i) |=> !busy);
    assert_ignore_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && done_i) |=> $stable(fatal_sts));
    assert_no_relaunch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_i) |=> (busy && !req_o));
endmodule

// File: rtl/cmdbuf_ctrl_regs.sv
module cmdbuf_ctrl_regs
    import cmdbuf_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [31:0] WIN_BASE    = 32'hFED4_0000,
    parameter logic [31:0] WIN_SIZE    = 32'h0000_1000,
    parameter logic [31:0] DATA_OFS    = 32'h0000_0080,
    parameter logic [15:0] VENDOR_CODE = 16'h1014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_len,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              est_flag,
    output logic              be_req,
    output logic              be_cancel,
    input  logic              be_done,
    input  logic              be_err
);
    localparam logic [31:0] BUF_SIZE = WIN_SIZE - DATA_OFS;
    localparam logic [31:0] BUF_ADDR = WIN_BASE + DATA_OFS;

    logic       hit_cmd_ready, hit_go_idle, hit_start, hit_cancel;
    logic       hit_loc_req, hit_loc_rel;
    logic [3:0] wr_loc;
    logic       held, granted, seized;
    logic       busy, idle_sts, fatal_sts;
    logic [31:0] word;

    cmdbuf_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(bus_wr), .addr(bus_addr), .len(bus_len), .wdata(bus_wdata),
        .hit_cmd_ready(hit_cmd_ready), .hit_go_idle(hit_go_idle),
        .hit_start(hit_start), .hit_cancel(hit_cancel),
        .hit_loc_req(hit_loc_req), .hit_loc_rel(hit_loc_rel),
        .wr_loc(wr_loc)
    );

    cmdbuf_loc_fsm u_loc (
        .clk(clk), .rst_n(rst_n),
        .hit_loc_req(hit_loc_req), .hit_loc_rel(hit_loc_rel),
        .held(held), .granted(granted), .seized(seized)
    );

    cmdbuf_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n),
        .hit_start(hit_start), .hit_cancel(hit_cancel),
        .hit_cmd_ready(hit_cmd_ready), .hit_go_idle(hit_go_idle),
        .loc_held(held), .wr_loc(wr_loc),
        .done_i(be_done), .err_i(be_err),
        .busy(busy), .idle_sts(idle_sts), .fatal_sts(fatal_sts),
        .req_o(be_req), .cancel_o(be_cancel)
    );

    always_comb begin
        word = '0;
        unique case ({bus_addr[11:2], 2'b00})
            OFS_LOCSTATE: begin
                word[0]    = ~est_flag;
                word[1]    = held;
                word[7]    = 1'b1;
                word[15:8] = held ? {4'd0, ACTIVE_LOC} : 8'hFF;
            end
            OFS_LOCSTS:  word[1:0] = {seized, granted};
            OFS_IFID:    word      = ifid_word();
            OFS_IFID2:   word      = {16'd0, VENDOR_CODE};
            OFS_CTLSTS:  word[1:0] = {idle_sts, fatal_sts};
            OFS_START:   word[0]   = busy;
            OFS_CMDSZ, OFS_RSPSZ:   word = BUF_SIZE;
            OFS_CMDADR, OFS_RSPADR: word = BUF_ADDR;
            default:     word      = '0;
        endcase
    end

    assign bus_rdata = word >> {bus_addr[1:0], 3'b000};

    assert_active_loc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:0] == OFS_LOCSTATE && !held) |-> (bus_rdata[15:8] == 8'hFF));
    assert_est_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:0] == OFS_LOCSTATE) |-> (bus_rdata[0] == !est_flag));
endmodule

// File: tb/test_cmdbuf_ctrl_regs.sv
`timescale 1ns/1ps
module test_cmdbuf_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_len = 2'd3;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        est_flag = 1'b1;
    logic        be_req, be_cancel;
    logic        be_done = 1'b0;
    logic        be_err = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cmdbuf_ctrl_regs i_cmdbuf_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .est_flag(est_flag), .be_req(be_req), .be_cancel(be_cancel),
        .be_done(be_done), .be_err(be_err)
    );

    typedef struct packed {
        logic        is_wr;
        logic [1:0]  len;
        logic [15:0] addr;
        logic [31:0] data;   // write data or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd3, 16'h000, 32'h0000FF80, 4'd1},   // R1 R4
        '{1'b0, 2'd3, 16'h044, 32'h00000002, 4'd1},   // R1
        '{1'b0, 2'd3, 16'h030, 32'h00024C11, 4'd1},   // R1
        '{1'b0, 2'd3, 16'h034, 32'h00001014, 4'd1},   // R1
        '{1'b0, 2'd3, 16'h058, 32'h00000F80, 4'd1},   // R1
        '{1'b0, 2'd3, 16'h05C, 32'hFED40080, 4'd1},   // R1
        '{1'b0, 2'd3, 16'h064, 32'h00000F80, 4'd1},   // R1
        '{1'b0, 2'd3, 16'h068, 32'hFED40080, 4'd1},   // R1
        '{1'b1, 2'd3, 16'h040, 32'h00000003, 4'd2},   // R2 bad code
        '{1'b0, 2'd3, 16'h044, 32'h00000002, 4'd2},
        '{1'b1, 2'd3, 16'h040, 32'h00000001, 4'd2},   // R2 command ready
        '{1'b0, 2'd3, 16'h044, 32'h00000000, 4'd2},
        '{1'b1, 2'd0, 16'h040, 32'h00000202, 4'd11},  // R11 lane = 0x02
        '{1'b0, 2'd3, 16'h044, 32'h00000002, 4'd11},
        '{1'b1, 2'd3, 16'h040, 32'h00000101, 4'd11},  // R11 full word ignored
        '{1'b0, 2'd3, 16'h044, 32'h00000002, 4'd11},
        '{1'b1, 2'd0, 16'h040, 32'h00000101, 4'd11},  // R11 lane = 0x01
        '{1'b0, 2'd3, 16'h044, 32'h00000000, 4'd11},
        '{1'b1, 2'd3, 16'h040, 32'h00000002, 4'd2},   // R2 go idle
        '{1'b1, 2'd3, 16'h008, 32'h00000004, 4'd3},   // R3 seize
        '{1'b0, 2'd3, 16'h000, 32'h0000FF80, 4'd3},
        '{1'b1, 2'd3, 16'h008, 32'h00000001, 4'd3},   // R3 request
        '{1'b0, 2'd3, 16'h00C, 32'h00000001, 4'd3},
        '{1'b0, 2'd3, 16'h000, 32'h00000082, 4'd4},   // R4
        '{1'b0, 2'd0, 16'h001, 32'h00000000, 4'd10},  // R10
        '{1'b0, 2'd3, 16'h031, 32'h0000024C, 4'd10},  // R10
        '{1'b0, 2'd1, 16'h032, 32'h00000002, 4'd10},  // R10
        '{1'b1, 2'd3, 16'h008, 32'h00000008, 4'd3},   // R3 reset-establishment
        '{1'b0, 2'd3, 16'h00C, 32'h00000001, 4'd3},
        '{1'b1, 2'd3, 16'h008, 32'h00000002, 4'd3},   // R3 relinquish
        '{1'b0, 2'd3, 16'h000, 32'h0000FF80, 4'd4}    // R4
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
    endtask

    // Write with optional concurrent completion; returns pulses seen the cycle after
    task automatic wr(input logic [15:0] a, input logic [1:0] l, input logic [31:0] d,
                      input logic dn, input logic er, output logic rq, output logic cn);
        @(negedge clk);
        bus_addr = a; bus_len = l; bus_wdata = d; bus_wr = 1'b1;
        be_done = dn; be_err = er;
        @(negedge clk);
        bus_wr = 1'b0; be_done = 1'b0; be_err = 1'b0; bus_len = 2'd3;
        rq = be_req; cn = be_cancel;
    endtask

    task automatic done_pulse(input logic er);
        @(negedge clk);
        be_done = 1'b1; be_err = er;
        @(negedge clk);
        be_done = 1'b0; be_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic rq, cn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr)
                wr(VEC[i].addr, VEC[i].len, VEC[i].data, 1'b0, 1'b0, rq, cn);
            else
                rd_chk(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec %0d", VEC[i].req, i));
        end

        // R10: established flag mirrored inverted
        est_flag = 1'b0;
        rd_chk(16'h000, 32'h0000FF81, "R10 est");

        // R6: start with no locality assigned
        wr(16'h04C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, rq}, 32'd0, "R6 unassigned req");
        rd_chk(16'h04C, 32'h0, "R6 unassigned start");

        wr(16'h008, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        // R6: wrong locality in address bits [15:12]
        wr(16'h104C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, rq}, 32'd0, "R6 locality req");
        rd_chk(16'h04C, 32'h0, "R6 locality start");
        // R6: inexact value
        wr(16'h04C, 2'd3, 32'h3, 1'b0, 1'b0, rq, cn);
        check({31'd0, rq}, 32'd0, "R6 value req");

        // R7: cancel while idle
        wr(16'h048, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, cn}, 32'd0, "R7 cancel idle");

        // R9: completion while idle, with error
        done_pulse(1'b1);
        rd_chk(16'h044, 32'h2, "R9 fatal untouched");

        // R5: accepted launch
        wr(16'h04C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, rq}, 32'd1, "R5 req pulse");
        rd_chk(16'h04C, 32'h1, "R5 start set");
        check({31'd0, be_req}, 32'd0, "R5 req one cycle");

        // R6: start while busy
        wr(16'h04C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, rq}, 32'd0, "R6 busy req");

        // R7: cancel in flight
        wr(16'h048, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, cn}, 32'd1, "R7 cancel pulse");
        @(negedge clk);
        check({31'd0, be_cancel}, 32'd0, "R7 cancel one cycle");

        // R8: clean completion
        done_pulse(1'b0);
        rd_chk(16'h04C, 32'h0, "R8 start cleared");
        rd_chk(16'h044, 32'h2, "R8 no fatal");

        // R8: completion with error
        wr(16'h04C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        done_pulse(1'b1);
        rd_chk(16'h044, 32'h3, "R8 fatal set");
        rd_chk(16'h04C, 32'h0, "R8 start cleared err");

        // R12: cancel write and completion in the same cycle
        wr(16'h04C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        check({31'd0, rq}, 32'd1, "R12 launch");
        wr(16'h048, 2'd3, 32'h1, 1'b1, 1'b0, rq, cn);
        check({31'd0, cn}, 32'd1, "R12 cancel pulse");
        rd_chk(16'h04C, 32'h0, "R12 start cleared");

        // R1: reset from a busy, held, fatal state
        wr(16'h04C, 2'd3, 32'h1, 1'b0, 1'b0, rq, cn);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(16'h044, 32'h2, "R1 ctlsts after reset");
        rd_chk(16'h04C, 32'h0, "R1 start after reset");
        rd_chk(16'h000, 32'h0000FF81, "R1 locstate after reset");
        rd_chk(16'h00C, 32'h0, "R1 locsts after reset");

        finish_run();
    end
endmodule